// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits in front of the line controller of a shared cache bank. It watches the heads of three inbound message queues: L1 unblocks, responses, and L1 requests. Each cycle it chooses one queue and turns the head message into a single protocol event code for the controller. It also reports which queue the event came from and which line address the event refers to.

The event does not follow from the opcode alone. An upgrade or a writeback is classified by whether the requester is currently a listed sharer of a present line. An acknowledgement is classified by comparing the carried ack count with the pending count. A request that misses while its set has no free way becomes a victim replacement event instead, dirty or clean, aimed at the victim's address. That request stays at the head of its queue so it can be retried once the way has been freed.

Tag lookup is done elsewhere: hit, free-way, victim address, victim dirty, sharer membership and pending-ack count all arrive as inputs. A queue head is popped only when the controller takes the event. A head with an unknown type is dropped at once and reported on an error output, with no event.

Top module: `coh_evt_classifier`

## Requirements
- R1: Queue priority is fixed: unblock (queue code 0) over response (1) over L1 request (2). A lower queue is not selected while a higher one is valid, unless a held event applies (R2). With no queue valid, evtQueue reads 3.
- R2: If an event is offered and evtReady is low, the same queue stays selected in the next cycle, even if a higher-priority queue has become valid. This holds until the event is taken or that queue's valid drops.
- R3: An upgrade request (reqType 3) gives the upgrade event (code 3) only when lineHit and reqIsSharer are both high. Otherwise it gives the exclusive-read event (code 2).
- R4: A writeback request (reqType 4) gives the owner-writeback event (code 4) when lineHit and reqIsSharer are both high. Otherwise it gives the stale-writeback event (code 5).
- R5: A request that has lineHit low and wayFree low gives a victim event, whatever its reqType: dirty (code 8) if victimDirty is high, clean (code 9) otherwise. evtAddr equals victimAddr, and reqPop stays low even when the event is taken.
- R6: A request that hits, or misses with a free way, uses evtAddr = reqAddr. Its reqType maps as follows: 0 shared read to code 0; 1 instruction read to code 1; 2 exclusive read to code 2; 5 speculative read to code 6; 6 expose to code 7.
- R7: An L1 response (respFromL1 high) of type 0 (data) gives code 10 if respDirty is high and code 11 if it is low.
- R8: An L1 response of type 1 (ack) gives the all-acks event (code 13) when pendAcks minus respAckCnt equals zero. Otherwise it gives the partial-ack event (code 12).
- R9: A memory response (respFromL1 low) maps type 0 to memory data (code 14), type 1 to memory ack (code 15) and type 2 to external invalidate (code 16).
- R10: Unknown types raise errValid with evtValid low and evtCode 31, and the head is popped in the same cycle regardless of evtReady. The unknown types are: reqType 7, L1 response types 2 and 3, memory response type 3, and unblock types 2 and 3. Unblock type 0 maps to code 17 and type 1 maps to code 18.
- R11: At most one pop is raised per cycle. Apart from R10 and R5, the selected queue is popped only in a cycle where evtValid and evtReady are both high.
- R12: With no queue valid, or while in reset with no queue valid, evtValid, errValid and all pops are low, and evtCode reads 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| unblkValid | input | 1 | Unblock queue head present |
| unblkType | input | 2 | Unblock type: 0 plain, 1 exclusive |
| unblkAddr | input | ADDR_W | Unblock line address |
| unblkPop | output | 1 | Remove unblock head |
| respValid | input | 1 | Response queue head present |
| respFromL1 | input | 1 | Response sender is an L1 (else memory) |
| respType | input | 2 | Response type, meaning per sender class |
| respDirty | input | 1 | Dirty flag of L1 data |
| respAckCnt | input | CNT_W | Ack count carried by an L1 ack |
| pendAcks | input | CNT_W | Pending ack count for the response's line |
| respAddr | input | ADDR_W | Response line address |
| respPop | output | 1 | Remove response head |
| reqValid | input | 1 | L1 request queue head present |
| reqType | input | 3 | Request opcode |
| reqAddr | input | ADDR_W | Request line address |
| reqIsSharer | input | 1 | Requester is a listed sharer |
| lineHit | input | 1 | Request line is present |
| wayFree | input | 1 | A free way exists in the request's set |
| victimAddr | input | ADDR_W | Address of the chosen victim |
| victimDirty | input | 1 | Victim holds dirty data |
| reqPop | output | 1 | Remove request head |
| evtReady | input | 1 | Controller accepts the event |
| evtValid | output | 1 | Event offered |
| evtCode | output | 5 | Event code (31 when none) |
| evtQueue | output | 2 | Selected queue (3 when none) |
| evtAddr | output | ADDR_W | Line address of the event |
| errValid | output | 1 | Selected head has an unknown type |

## Verification
Classification, selection, error and pop outputs are combinational from the queue heads and the lock state, so they are due in the same cycle as the stimulus. A pop takes effect at the next rising edge. A held selection (R2) is visible one edge after a refused offer. The bench changes inputs on the falling edge and samples 2 ns later, before the rising edge, so every sample sees settled logic from the current inputs and the lock as it stands after the previous edge. The hold test spans several edges and checks the selection in each of them.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;

  localparam int NUM_Q = 3;

  // queue identifiers; index into one-hot pick vectors
  typedef enum logic [1:0] {
    Q_UNBLK = 2'd0,
    Q_RESP  = 2'd1,
    Q_REQ   = 2'd2,
    Q_NONE  = 2'd3
  } qid_e;

  typedef enum logic [4:0] {
    EV_RD_SHARED    = 5'd0,
    EV_RD_INSTR     = 5'd1,
    EV_RD_EXCL      = 5'd2,
    EV_UPGRADE      = 5'd3,
    EV_WB_OWNER     = 5'd4,
    EV_WB_STALE     = 5'd5,
    EV_RD_SPEC      = 5'd6,
    EV_EXPOSE       = 5'd7,
    EV_VICT_DIRTY   = 5'd8,
    EV_VICT_CLEAN   = 5'd9,
    EV_L1_DATA_DRT  = 5'd10,
    EV_L1_DATA_CLN  = 5'd11,
    EV_ACK_PART     = 5'd12,
    EV_ACK_ALL      = 5'd13,
    EV_MEM_DATA     = 5'd14,
    EV_MEM_ACK      = 5'd15,
    EV_EXT_INV      = 5'd16,
    EV_UNBLOCK      = 5'd17,
    EV_UNBLOCK_EXCL = 5'd18,
    EV_NONE         = 5'd31
  } evt_e;

  // request opcodes
  localparam logic [2:0] OP_RD_SHARED = 3'd0;
  localparam logic [2:0] OP_RD_INSTR  = 3'd1;
  localparam logic [2:0] OP_RD_EXCL   = 3'd2;
  localparam logic [2:0] OP_UPGRADE   = 3'd3;
  localparam logic [2:0] OP_WRITEBACK = 3'd4;
  localparam logic [2:0] OP_RD_SPEC   = 3'd5;
  localparam logic [2:0] OP_EXPOSE    = 3'd6;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_Q-1:0] pick;   // one-hot selected queue, bit 0 = unblock
    logic             evtOn;  // selected head yields a real event
  } ctlStrobe_t;

endpackage

// File: rtl/coh_evt_datapath.sv
module coh_evt_datapath
  import coh_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        unblkType,
  input  logic [ADDR_W-1:0] unblkAddr,
  input  logic              respFromL1,
  input  logic [1:0]        respType,
  input  logic              respDirty,
  input  logic [CNT_W-1:0]  respAckCnt,
  input  logic [CNT_W-1:0]  pendAcks,
  input  logic [ADDR_W-1:0] respAddr,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsSharer,
  input  logic              lineHit,
  input  logic              wayFree,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              victimDirty,
  output logic [NUM_Q-1:0]  qErr,
  output logic              reqKeep,
  output logic [4:0]        evtCode,
  output logic [1:0]        evtQueue,
  output logic [ADDR_W-1:0] evtAddr
);

  evt_e              qCode [NUM_Q];
  logic [ADDR_W-1:0] qAddr [NUM_Q];
  logic [CNT_W-1:0]  ackLeft;
  logic              ownerOk;
  evt_e              selCode;

  assign ackLeft = pendAcks - respAckCnt;
  assign ownerOk = lineHit && reqIsSharer;
  assign reqKeep = !lineHit && !wayFree;

  // unblock queue
  always_comb begin
    qErr[0]  = 1'b0;
    qAddr[0] = unblkAddr;
    unique case (unblkType)
      2'd0:    qCode[0] = EV_UNBLOCK;
      2'd1:    qCode[0] = EV_UNBLOCK_EXCL;
      default: begin qCode[0] = EV_NONE; qErr[0] = 1'b1; end
    endcase
  end

  // response queue: L1 senders and memory senders decode differently
  always_comb begin
    qErr[1]  = 1'b0;
    qAddr[1] = respAddr;
    qCode[1] = EV_NONE;
    if (respFromL1) begin
      unique case (respType)
        2'd0:    qCode[1] = respDirty ? EV_L1_DATA_DRT : EV_L1_DATA_CLN;
        2'd1:    qCode[1] = (ackLeft == '0) ? EV_ACK_ALL : EV_ACK_PART;
        default: qErr[1]  = 1'b1;
      endcase
    end else begin
      unique case (respType)
        2'd0:    qCode[1] = EV_MEM_DATA;
        2'd1:    qCode[1] = EV_MEM_ACK;
        2'd2:    qCode[1] = EV_EXT_INV;
        default: qErr[1]  = 1'b1;
      endcase
    end
  end

  // request queue: victim replacement takes precedence over the opcode
  always_comb begin
    qErr[2]  = 1'b0;
    qAddr[2] = reqAddr;
    qCode[2] = EV_NONE;
    if (reqKeep) begin
      qCode[2] = victimDirty ? EV_VICT_DIRTY : EV_VICT_CLEAN;
      qAddr[2] = victimAddr;
    end else begin
      unique case (reqType)
        OP_RD_SHARED: qCode[2] = EV_RD_SHARED;
        OP_RD_INSTR:  qCode[2] = EV_RD_INSTR;
        OP_RD_EXCL:   qCode[2] = EV_RD_EXCL;
        OP_UPGRADE:   qCode[2] = ownerOk ? EV_UPGRADE : EV_RD_EXCL;
        OP_WRITEBACK: qCode[2] = ownerOk ? EV_WB_OWNER : EV_WB_STALE;
        OP_RD_SPEC:   qCode[2] = EV_RD_SPEC;
        OP_EXPOSE:    qCode[2] = EV_EXPOSE;
        default:      qErr[2]  = 1'b1;
      endcase
    end
  end

  // output mux driven by the one-hot pick
  always_comb begin
    selCode  = EV_NONE;
    evtAddr  = '0;
    evtQueue = Q_NONE;
    for (int i = 0; i < NUM_Q; i++) begin
      if (strobe.pick[i]) begin
        selCode  = qCode[i];
        evtAddr  = qAddr[i];
        evtQueue = 2'(i);
      end
    end
  end

  assign evtCode = strobe.evtOn ? selCode : EV_NONE;

  // R5: a victim event always names the victim line
  p_victim_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evtOn && strobe.pick[2] && !lineHit && !wayFree) |-> (evtAddr == victimAddr));

  // R3: upgrade only for a present line held by the requester
  p_upgrade_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtCode == EV_UPGRADE) |-> (lineHit && reqIsSharer && strobe.pick[2]));

  // R8: all-acks only when the carried count drains the pending count
  p_ack_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evtCode == EV_ACK_ALL) |-> (pendAcks == respAckCnt));

endmodule

// File: rtl/coh_evt_ctrl.sv
module coh_evt_ctrl
  import coh_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_Q-1:0] qValid,
  input  logic [NUM_Q-1:0] qErr,
  input  logic             reqKeep,
  input  logic             evtReady,
  output ctlStrobe_t       strobe,
  output logic             evtValid,
  output logic             errValid,
  output logic [NUM_Q-1:0] qPop
);

  logic [NUM_Q-1:0] prioPick;
  logic [NUM_Q-1:0] lockQ;
  logic [NUM_Q-1:0] pick;
  logic             anyPick;
  logic             errHit;
  logic             keepHead;

  // fixed priority: lowest index wins
  always_comb begin
    prioPick = '0;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (qValid[i]) prioPick = NUM_Q'(1) << i;
    end
  end

  assign pick     = (lockQ != '0) ? (lockQ & qValid) : prioPick;
  assign anyPick  = |pick;
  assign errHit   = |(pick & qErr);
  assign evtValid = anyPick && !errHit;
  assign errValid = anyPick && errHit;
  assign keepHead = pick[2] && reqKeep;

  always_comb begin
    qPop = '0;
    if (errValid)                               qPop = pick;
    else if (evtValid && evtReady && !keepHead) qPop = pick;
  end

  // hold the selection while an offered event waits
  always_ff @(posedge clk) begin
    if (!rstN)                      lockQ <= '0;
    else if (evtValid && !evtReady) lockQ <= pick;
    else                            lockQ <= '0;
  end

  assign strobe.pick  = pick;
  assign strobe.evtOn = evtValid;

  // R11: never more than one queue popped
  p_single_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(qPop));

  // R11: a good head leaves only on acceptance
  p_pop_on_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((|qPop) && !errValid) |-> (evtValid && evtReady));

  // R2: refused offer keeps the same queue while it stays valid
  p_hold_queue_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady) |=>
      ((pick == $past(pick)) || ((qValid & $past(pick)) == '0)));

  // R5: a replacement never consumes the request
  p_keep_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pick[2] && reqKeep && !errValid) |-> !qPop[2]);

  // R1: unblock wins when nothing is held
  p_prio_unblk_r1: assert property (@(posedge clk) disable iff (!rstN)
    (qValid[0] && !$past(evtValid && !evtReady)) |-> pick[0]);

endmodule

// File: rtl/coh_evt_classifier.sv
module coh_evt_classifier
  import coh_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unblkValid,
  input  logic [1:0]        unblkType,
  input  logic [ADDR_W-1:0] unblkAddr,
  output logic              unblkPop,
  input  logic              respValid,
  input  logic              respFromL1,
  input  logic [1:0]        respType,
  input  logic              respDirty,
  input  logic [CNT_W-1:0]  respAckCnt,
  input  logic [CNT_W-1:0]  pendAcks,
  input  logic [ADDR_W-1:0] respAddr,
  output logic              respPop,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsSharer,
  input  logic              lineHit,
  input  logic              wayFree,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              victimDirty,
  output logic              reqPop,
  input  logic              evtReady,
  output logic              evtValid,
  output logic [4:0]        evtCode,
  output logic [1:0]        evtQueue,
  output logic [ADDR_W-1:0] evtAddr,
  output logic              errValid
);

  ctlStrobe_t       strobe;
  logic [NUM_Q-1:0] qErr;
  logic [NUM_Q-1:0] qPop;
  logic             reqKeep;

  coh_evt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .qValid   ({reqValid, respValid, unblkValid}),
    .qErr     (qErr),
    .reqKeep  (reqKeep),
    .evtReady (evtReady),
    .strobe   (strobe),
    .evtValid (evtValid),
    .errValid (errValid),
    .qPop     (qPop)
  );

  coh_evt_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .unblkType   (unblkType),
    .unblkAddr   (unblkAddr),
    .respFromL1  (respFromL1),
    .respType    (respType),
    .respDirty   (respDirty),
    .respAckCnt  (respAckCnt),
    .pendAcks    (pendAcks),
    .respAddr    (respAddr),
    .reqType     (reqType),
    .reqAddr     (reqAddr),
    .reqIsSharer (reqIsSharer),
    .lineHit     (lineHit),
    .wayFree     (wayFree),
    .victimAddr  (victimAddr),
    .victimDirty (victimDirty),
    .qErr        (qErr),
    .reqKeep     (reqKeep),
    .evtCode     (evtCode),
    .evtQueue    (evtQueue),
    .evtAddr     (evtAddr)
  );

  assign unblkPop = qPop[0];
  assign respPop  = qPop[1];
  assign reqPop   = qPop[2];

endmodule

// File: tb/coh_evt_classifier_tb.sv
`timescale 1ns/1ps
module coh_evt_classifier_tb_top;

  localparam int AW = 32;
  localparam int CW = 6;
  localparam logic [AW-1:0] U_ADDR = 32'h1111_0040;
  localparam logic [AW-1:0] R_ADDR = 32'h2222_0080;
  localparam logic [AW-1:0] Q_ADDR = 32'h3333_00C0;
  localparam logic [AW-1:0] V_ADDR = 32'h4444_0100;

  logic clk = 1'b0;
  logic rstN;
  logic unblkValid, respValid, reqValid;
  logic [1:0] unblkType, respType;
  logic respFromL1, respDirty, reqIsSharer, lineHit, wayFree, victimDirty, evtReady;
  logic [CW-1:0] respAckCnt, pendAcks;
  logic [2:0] reqType;
  logic unblkPop, respPop, reqPop, evtValid, errValid;
  logic [4:0] evtCode;
  logic [1:0] evtQueue;
  logic [AW-1:0] evtAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coh_evt_classifier #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN),
    .unblkValid(unblkValid), .unblkType(unblkType), .unblkAddr(U_ADDR), .unblkPop(unblkPop),
    .respValid(respValid), .respFromL1(respFromL1), .respType(respType), .respDirty(respDirty),
    .respAckCnt(respAckCnt), .pendAcks(pendAcks), .respAddr(R_ADDR), .respPop(respPop),
    .reqValid(reqValid), .reqType(reqType), .reqAddr(Q_ADDR), .reqIsSharer(reqIsSharer),
    .lineHit(lineHit), .wayFree(wayFree), .victimAddr(V_ADDR), .victimDirty(victimDirty),
    .reqPop(reqPop), .evtReady(evtReady), .evtValid(evtValid), .evtCode(evtCode),
    .evtQueue(evtQueue), .evtAddr(evtAddr), .errValid(errValid)
  );

  typedef struct packed {
    logic uV; logic [1:0] uT;
    logic rV; logic rL1; logic [1:0] rT; logic rD; logic [5:0] rAck; logic [5:0] pend;
    logic qV; logic [2:0] qT; logic qShr; logic qHit; logic qFree; logic qVicD;
    logic eV; logic eE; logic [4:0] eCode; logic [1:0] eQ; logic [1:0] eSel; logic [2:0] ePops;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 29;
  // fields: uV uT | rV rL1 rT rD rAck pend | qV qT qShr qHit qFree qVicD | eV eE code q sel pops{req,resp,unblk} tag
  localparam vec_t VECS [NV] = '{
    '{0,0, 0,0,0,0,0,0, 1,0,0,1,1,0, 1,0, 0,2,2,3'b100, 6},  // R6 shared read hit
    '{0,0, 0,0,0,0,0,0, 1,1,0,0,1,0, 1,0, 1,2,2,3'b100, 6},  // R6 instr read, miss free way
    '{0,0, 0,0,0,0,0,0, 1,2,0,1,0,0, 1,0, 2,2,2,3'b100, 6},  // R6 exclusive read
    '{0,0, 0,0,0,0,0,0, 1,5,0,1,1,0, 1,0, 6,2,2,3'b100, 6},  // R6 speculative read
    '{0,0, 0,0,0,0,0,0, 1,6,0,1,1,0, 1,0, 7,2,2,3'b100, 6},  // R6 expose
    '{0,0, 0,0,0,0,0,0, 1,3,1,1,0,0, 1,0, 3,2,2,3'b100, 3},  // R3 upgrade by sharer
    '{0,0, 0,0,0,0,0,0, 1,3,0,1,0,0, 1,0, 2,2,2,3'b100, 3},  // R3 upgrade by non-sharer
    '{0,0, 0,0,0,0,0,0, 1,3,1,0,1,0, 1,0, 2,2,2,3'b100, 3},  // R3 upgrade, line absent
    '{0,0, 0,0,0,0,0,0, 1,4,1,1,0,0, 1,0, 4,2,2,3'b100, 4},  // R4 writeback by sharer
    '{0,0, 0,0,0,0,0,0, 1,4,0,1,0,0, 1,0, 5,2,2,3'b100, 4},  // R4 stale writeback
    '{0,0, 0,0,0,0,0,0, 1,0,0,0,0,1, 1,0, 8,2,3,3'b000, 5},  // R5 dirty victim
    '{0,0, 0,0,0,0,0,0, 1,4,1,0,0,0, 1,0, 9,2,3,3'b000, 5},  // R5 clean victim
    '{0,0, 0,0,0,0,0,0, 1,7,0,1,1,0, 0,1,31,2,2,3'b100,10},  // R10 illegal request
    '{0,0, 1,1,0,1,0,0, 0,0,0,0,0,0, 1,0,10,1,1,3'b010, 7},  // R7 dirty L1 data
    '{0,0, 1,1,0,0,0,0, 0,0,0,0,0,0, 1,0,11,1,1,3'b010, 7},  // R7 clean L1 data
    '{0,0, 1,1,1,0,3,3, 0,0,0,0,0,0, 1,0,13,1,1,3'b010, 8},  // R8 ack drains count
    '{0,0, 1,1,1,0,1,3, 0,0,0,0,0,0, 1,0,12,1,1,3'b010, 8},  // R8 partial ack
    '{0,0, 1,1,1,0,0,0, 0,0,0,0,0,0, 1,0,13,1,1,3'b010, 8},  // R8 zero and zero
    '{0,0, 1,0,0,0,0,0, 0,0,0,0,0,0, 1,0,14,1,1,3'b010, 9},  // R9 memory data
    '{0,0, 1,0,1,0,0,0, 0,0,0,0,0,0, 1,0,15,1,1,3'b010, 9},  // R9 memory ack
    '{0,0, 1,0,2,0,0,0, 0,0,0,0,0,0, 1,0,16,1,1,3'b010, 9},  // R9 external invalidate
    '{0,0, 1,0,3,0,0,0, 0,0,0,0,0,0, 0,1,31,1,1,3'b010,10},  // R10 bad memory type
    '{0,0, 1,1,2,0,0,0, 0,0,0,0,0,0, 0,1,31,1,1,3'b010,10},  // R10 bad L1 type
    '{1,0, 0,0,0,0,0,0, 0,0,0,0,0,0, 1,0,17,0,0,3'b001,10},  // R10 plain unblock
    '{1,1, 0,0,0,0,0,0, 0,0,0,0,0,0, 1,0,18,0,0,3'b001,10},  // R10 exclusive unblock
    '{1,2, 0,0,0,0,0,0, 0,0,0,0,0,0, 0,1,31,0,0,3'b001,10},  // R10 bad unblock type
    '{1,0, 1,0,0,0,0,0, 1,0,0,1,1,0, 1,0,17,0,0,3'b001, 1},  // R1 all three valid
    '{0,0, 1,0,1,0,0,0, 1,0,0,1,1,0, 1,0,15,1,1,3'b010, 1},  // R1 response over request
    '{1,3, 1,0,0,0,0,0, 0,0,0,0,0,0, 0,1,31,0,0,3'b001, 1}   // R1 erroneous unblock first
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    unblkValid = 0; unblkType = 0;
    respValid = 0; respFromL1 = 0; respType = 0; respDirty = 0; respAckCnt = 0; pendAcks = 0;
    reqValid = 0; reqType = 0; reqIsSharer = 0; lineHit = 0; wayFree = 0; victimDirty = 0;
    evtReady = 0;
  endtask

  function automatic logic [AW-1:0] selAddr(input logic [1:0] s);
    case (s)
      2'd0: return U_ADDR;
      2'd1: return R_ADDR;
      2'd2: return Q_ADDR;
      default: return V_ADDR;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (2) @(negedge clk);
    #2;
    // R12 idle in reset
    check(!evtValid && !errValid && evtCode == 5'd31 && evtQueue == 2'd3 &&
          {reqPop, respPop, unblkPop} == 3'b000, "R12", "reset idle",
          {evtValid, errValid, evtCode, evtQueue}, {1'b0, 1'b0, 5'd31, 2'd3});
    @(negedge clk); rstN = 1;
    #2;
    check(!evtValid && evtCode == 5'd31 && {reqPop, respPop, unblkPop} == 3'b000,
          "R12", "idle after reset", {evtValid, evtCode}, {1'b0, 5'd31});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clearIn();
      evtReady = 1;
      unblkValid = VECS[i].uV; unblkType = VECS[i].uT;
      respValid = VECS[i].rV; respFromL1 = VECS[i].rL1; respType = VECS[i].rT;
      respDirty = VECS[i].rD; respAckCnt = VECS[i].rAck; pendAcks = VECS[i].pend;
      reqValid = VECS[i].qV; reqType = VECS[i].qT; reqIsSharer = VECS[i].qShr;
      lineHit = VECS[i].qHit; wayFree = VECS[i].qFree; victimDirty = VECS[i].qVicD;
      #2;
      check(evtValid == VECS[i].eV && errValid == VECS[i].eE && evtCode == VECS[i].eCode &&
            evtQueue == VECS[i].eQ && {reqPop, respPop, unblkPop} == VECS[i].ePops &&
            (!VECS[i].eV || evtAddr == selAddr(VECS[i].eSel)),
            $sformatf("R%0d", VECS[i].tag), $sformatf("vector %0d v/e/code/q/pops", i),
            {evtValid, errValid, evtCode, evtQueue, reqPop, respPop, unblkPop},
            {VECS[i].eV, VECS[i].eE, VECS[i].eCode, VECS[i].eQ, VECS[i].ePops});
    end

    // R5 victim event repeats next cycle, request still at head
    @(negedge clk);
    clearIn(); evtReady = 1; reqValid = 1; reqType = 3'd0; victimDirty = 1;
    @(negedge clk); #2;
    check(evtValid && evtCode == 5'd8 && evtAddr == V_ADDR && !reqPop, "R5",
          "victim retry", {evtCode, reqPop}, {5'd8, 1'b0});

    // R11 refused offer pops nothing
    @(negedge clk);
    clearIn(); respValid = 1; respType = 2'd0; evtReady = 0;
    #2;
    check(evtValid && evtQueue == 2'd1 && {reqPop, respPop, unblkPop} == 3'b000, "R11",
          "no pop without ready", {evtQueue, reqPop, respPop, unblkPop}, {2'd1, 3'b000});
    // R2 higher queue arrives while response is held
    @(negedge clk);
    unblkValid = 1; unblkType = 2'd0;
    #2;
    check(evtQueue == 2'd1 && evtCode == 5'd14 && !unblkPop && !respPop, "R2",
          "held selection", {evtQueue, evtCode}, {2'd1, 5'd14});
    @(negedge clk); #2;
    check(evtQueue == 2'd1 && !unblkPop, "R2", "still held", evtQueue, 2'd1);
    @(negedge clk);
    evtReady = 1;
    #2;
    check(respPop && !unblkPop && evtQueue == 2'd1, "R11", "pop on accept",
          {respPop, unblkPop}, 2'b10);
    @(negedge clk);
    respValid = 0;
    #2;
    check(evtQueue == 2'd0 && evtCode == 5'd17 && unblkPop, "R1", "unblock after release",
          {evtQueue, evtCode}, {2'd0, 5'd17});

    // R10 erroneous head dropped without ready
    @(negedge clk);
    clearIn(); unblkValid = 1; unblkType = 2'd3; evtReady = 0;
    #2;
    check(errValid && !evtValid && unblkPop && evtCode == 5'd31, "R10",
          "error pops without ready", {errValid, evtValid, unblkPop}, 3'b101);

    // R12 idle again
    @(negedge clk);
    clearIn();
    #2;
    check(!evtValid && !errValid && evtQueue == 2'd3 && {reqPop, respPop, unblkPop} == 3'b000,
          "R12", "idle", {evtValid, errValid, evtQueue}, {1'b0, 1'b0, 2'd3});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule